// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver with Raw Sample Capture

This block decodes an asynchronous serial line carrying frames of one start bit, eight data bits, no parity and one stop bit at 500 kbit/s. Every register runs on every edge of a 40 MHz clock. An internal divider issues a sample strobe once every 5 clocks (8 MHz), which gives exactly 16 strobes per 2 µs bit. Because the strobe comes from a free-running counter and not from a delay inside the datapath, the sampling interval stays fixed however much logic sits between sampling and the outputs.

A falling edge seen on a strobe while the receiver is idle opens a frame. The start bit is confirmed on its 8th strobe. Each data bit is taken on its own 8th strobe, least significant bit first. When the stop bit has been sampled, the assembled byte is presented with a one-cycle valid pulse, and a framing-error flag is raised if the stop bit read low.

For debug capture, every raw strobe sample of an accepted frame (160 per frame) is also streamed out in arrival order on a separate valid/bit output. The stream runs a fixed 8 strobes behind the line, so a frame rejected on a false start can be withdrawn before any of its samples leave the block.

Top module: `uart_os_rx`

## Requirements
- R1: The serial input passes through two flip-flops, both reset to 1, before it is sampled.
- R2: The sample strobe is active for one clock in every 5, starting 5 clocks after reset is released. Consecutive capture pulses are never closer than 5 clocks.
- R3: While idle, a strobe that sees the line low after a strobe that saw it high is taken as strobe 1 of a start bit.
- R4: If the line reads high on strobe 8 of the start bit, the frame is dropped. It produces no byte pulse and no capture pulse, and the receiver returns to idle.
- R5: Data bit k (k = 0..7) is the line value on strobe 8 of bit period k+1 after the start bit, and it is placed at data_o bit k.
- R6: data_valid_o is a single-cycle pulse, issued on the clock after strobe 8 of the stop bit. data_o holds the byte until the next pulse.
- R7: frame_err_o is 1 during the data_valid_o pulse exactly when the stop bit read 0 on its strobe 8. It is 0 at all other times.
- R8: Each accepted frame yields exactly 160 single-cycle capture pulses on cap_valid_o, one per strobe from start-bit strobe 1 to stop-bit strobe 16, with cap_bit_o carrying the sampled value, in order and delayed by 8 strobes.
- R9: While rst_ni is low, all outputs are 0.
- R10: A start edge on the strobe right after stop-bit strobe 16 begins a new frame with no lost samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 40 MHz system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| data_o | output | 8 | Last received byte |
| data_valid_o | output | 1 | One-cycle pulse when a byte is ready |
| frame_err_o | output | 1 | Stop bit was low, valid with the byte pulse |
| cap_valid_o | output | 1 | One-cycle pulse per raw sample of an accepted frame |
| cap_bit_o | output | 1 | Raw sample value, meaningful with cap_valid_o |

## Verification
Frames with alternating bits (0x55), all zeros, all ones and a mixed value (0xA3) separate bit-order and bit-position faults from stuck bits. Two frames sent back to back with no idle gap test re-arming on the very next strobe. A 15-clock low glitch produces a start that reads high at its centre strobe, which must yield neither a byte nor any capture samples. A frame with a low stop bit must raise the error flag with its byte, while the frame that follows must not.

// File: rtl/uart_os_pkg.sv
package uart_os_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  typedef struct packed {
    logic vld;
    logic smp;
  } cap_ent_t;

endpackage

// File: rtl/uart_os_sync.sv
module uart_os_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/uart_os_tick.sv
module uart_os_tick #(
  parameter int DIV = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/uart_os_frame.sv
module uart_os_frame
  import uart_os_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic              ferr_o,
  output logic              push_o,
  output logic              abort_o
);

  localparam int SCW = $clog2(OSR);
  localparam int BCW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [SCW-1:0] MID  = SCW'(OSR / 2 - 1);
  localparam logic [SCW-1:0] LAST = SCW'(OSR - 1);
  localparam logic [BCW-1:0] BLST = BCW'(DATA_W - 1);

  rx_state_e         state_q;
  logic [SCW-1:0]    smp_cnt_q;
  logic [BCW-1:0]    bit_cnt_q;
  logic [DATA_W-1:0] shreg_q;
  logic              prev_q;

  logic start_edge, at_mid, at_last;

  assign start_edge = (state_q == ST_IDLE) && prev_q && !rx_i;
  assign at_mid     = (smp_cnt_q == MID);
  assign at_last    = (smp_cnt_q == LAST);
  assign push_o     = tick_i && (start_edge || state_q != ST_IDLE);
  assign abort_o    = tick_i && (state_q == ST_START) && at_mid && rx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      smp_cnt_q  <= '0;
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
      prev_q     <= 1'b1;
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
      ferr_o     <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      ferr_o     <= 1'b0;
      if (tick_i) begin
        prev_q <= rx_i;
        unique case (state_q)
          ST_IDLE: begin
            if (start_edge) begin
              state_q   <= ST_START;
              smp_cnt_q <= SCW'(1);
            end
          end
          ST_START: begin
            if (at_mid && rx_i) begin
              // false start
              state_q   <= ST_IDLE;
              smp_cnt_q <= '0;
            end else if (at_last) begin
              state_q   <= ST_DATA;
              smp_cnt_q <= '0;
              bit_cnt_q <= '0;
            end else begin
              smp_cnt_q <= smp_cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (at_mid) shreg_q <= {rx_i, shreg_q[DATA_W-1:1]};
            if (at_last) begin
              smp_cnt_q <= '0;
              if (bit_cnt_q == BLST) state_q <= ST_STOP;
              else bit_cnt_q <= bit_cnt_q + 1'b1;
            end else begin
              smp_cnt_q <= smp_cnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (at_mid) begin
              byte_o     <= shreg_q;
              byte_vld_o <= 1'b1;
              ferr_o     <= !rx_i;
            end
            if (at_last) begin
              state_q   <= ST_IDLE;
              smp_cnt_q <= '0;
            end else begin
              smp_cnt_q <= smp_cnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/uart_os_cap.sv
module uart_os_cap
  import uart_os_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic push_i,
  input  logic abort_i,
  input  logic smp_i,
  output logic cap_valid_o,
  output logic cap_bit_o
);

  cap_ent_t line_q [DEPTH];

  // Head leaves before a flush, so only the aborted frame's samples are dropped.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q[0] <= '0;
    end else if (tick_i) begin
      line_q[0].vld <= push_i && !abort_i;
      line_q[0].smp <= smp_i;
    end
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        line_q[g] <= '0;
      end else if (tick_i) begin
        line_q[g].vld <= line_q[g-1].vld && !abort_i;
        line_q[g].smp <= line_q[g-1].smp;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_valid_o <= 1'b0;
      cap_bit_o   <= 1'b0;
    end else begin
      cap_valid_o <= tick_i && line_q[DEPTH-1].vld;
      if (tick_i) cap_bit_o <= line_q[DEPTH-1].smp;
    end
  end

endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int CLK_DIV = 5,
  parameter int OSR     = 16,
  parameter int DATA_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_valid_o,
  output logic              frame_err_o,
  output logic              cap_valid_o,
  output logic              cap_bit_o
);

  localparam int CAP_DLY = OSR / 2;

  logic rx_s, smp_en, push, abort;

  uart_os_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rx_s)
  );

  uart_os_tick #(.DIV(CLK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(smp_en)
  );

  uart_os_frame #(.OSR(OSR), .DATA_W(DATA_W)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (smp_en),
    .rx_i      (rx_s),
    .byte_o    (data_o),
    .byte_vld_o(data_valid_o),
    .ferr_o    (frame_err_o),
    .push_o    (push),
    .abort_o   (abort)
  );

  uart_os_cap #(.DEPTH(CAP_DLY)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (smp_en),
    .push_i     (push),
    .abort_i    (abort),
    .smp_i      (rx_s),
    .cap_valid_o(cap_valid_o),
    .cap_bit_o  (cap_bit_o)
  );

endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
  parameter int CLK_DIV = 5
) (
  input logic clk_i,
  input logic rst_ni,
  input logic smp_en,
  input logic data_valid_o,
  input logic frame_err_o,
  input logic cap_valid_o
);

  int unsigned gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gap_q <= 0;
    else if (smp_en) gap_q <= 0;
    else             gap_q <= gap_q + 1;
  end

  // R2
  tick_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_en |-> (gap_q == CLK_DIV - 1));

  // R2
  cap_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_valid_o |=> !cap_valid_o);

  // R6
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |=> !data_valid_o);

  // R7
  ferr_with_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> data_valid_o);

endmodule

bind uart_os_rx uart_os_rx_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .smp_en      (smp_en),
  .data_valid_o(data_valid_o),
  .frame_err_o (frame_err_o),
  .cap_valid_o (cap_valid_o)
);

// File: tb/uart_os_rx_bench.sv
module uart_os_rx_bench;

  localparam int DIV = 5, OSR = 16, W = 8;
  localparam int BITCLK = DIV * OSR;
  localparam int FRAME_SMP = OSR * (W + 2);

  logic clk = 1'b0, rst_ni = 1'b0, rxd = 1'b1;
  logic [W-1:0] data_o;
  logic data_valid_o, frame_err_o, cap_valid_o, cap_bit_o;

  always #10 clk = ~clk;

  uart_os_rx u_uart_os_rx (
    .clk_i(clk), .rst_ni(rst_ni), .rxd_i(rxd),
    .data_o(data_o), .data_valid_o(data_valid_o), .frame_err_o(frame_err_o),
    .cap_valid_o(cap_valid_o), .cap_bit_o(cap_bit_o)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // stimulus-side scoreboard
  int sb_byte[$];
  int sb_err[$];
  int frames_ok = 0;
  int cap_cnt = 0;
  int cyc = 0, last_cap = -100;

  // behavioural reference
  int m_s1, m_s2, m_cnt, m_prev, m_pos;
  int m_q[$];
  logic [W-1:0] m_byte;
  logic e_dv = 0, e_fe = 0, e_cv = 0, e_cb = 0;
  logic [W-1:0] e_data = '0;

  always @(posedge clk) begin
    int rs, hd;
    bit tk, ab;
    if (!rst_ni) begin
      m_s1 = 1; m_s2 = 1; m_cnt = 0; m_prev = 1; m_pos = -1; m_byte = '0;
      m_q.delete();
      for (int i = 0; i < OSR / 2; i++) m_q.push_back(-1);
      e_dv = 0; e_fe = 0; e_cv = 0; e_cb = 0; e_data = '0;
    end else begin
      // R1: two-flop delay
      rs = m_s2; m_s2 = m_s1; m_s1 = int'(rxd);
      tk = (m_cnt == DIV - 1);
      m_cnt = tk ? 0 : m_cnt + 1;
      e_dv = 0; e_fe = 0; e_cv = 0;
      if (tk) begin
        ab = 0;
        if (m_pos < 0 && m_prev == 1 && rs == 0) m_pos = 0;
        hd = m_q.pop_front();
        e_cv = (hd >= 0);
        if (hd >= 0) e_cb = hd[0];
        if (m_pos >= 0) begin
          m_q.push_back(rs);
          if (m_pos == OSR / 2 - 1 && rs == 1) ab = 1;
          else if (m_pos >= OSR && m_pos < OSR * (W + 1) && m_pos % OSR == OSR / 2 - 1)
            m_byte[m_pos / OSR - 1] = rs[0];
          else if (m_pos == OSR * (W + 1) + OSR / 2 - 1) begin
            e_dv = 1; e_fe = (rs == 0); e_data = m_byte;
          end
          m_pos = ab ? -1 : m_pos + 1;
          if (m_pos == FRAME_SMP) m_pos = -1;
        end else begin
          m_q.push_back(-1);
        end
        if (ab) foreach (m_q[i]) m_q[i] = -1;
        m_prev = rs;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cyc++;
      chk(data_valid_o == e_dv, "R6 data_valid_o", int'(data_valid_o), int'(e_dv));
      chk(frame_err_o == e_fe, "R7 frame_err_o", int'(frame_err_o), int'(e_fe));
      chk(data_o == e_data, "R5 data_o", int'(data_o), int'(e_data));
      chk(cap_valid_o == e_cv, "R8 cap_valid_o", int'(cap_valid_o), int'(e_cv));
      if (e_cv) chk(cap_bit_o == e_cb, "R8 cap_bit_o", int'(cap_bit_o), int'(e_cb));
      if (cap_valid_o) begin
        // R2 spacing
        chk(cyc - last_cap >= DIV, "R2 capture spacing", cyc - last_cap, DIV);
        last_cap = cyc;
        cap_cnt++;
      end
      if (data_valid_o && rst_ni) begin
        if (sb_byte.size() == 0) begin
          chk(0, "R4 unexpected byte", int'(data_o), -1);
        end else begin
          int eb, ee;
          eb = sb_byte.pop_front();
          ee = sb_err.pop_front();
          chk(int'(data_o) == eb, "R5 scoreboard byte", int'(data_o), eb);
          chk(int'(frame_err_o) == ee, "R7 scoreboard error", int'(frame_err_o), ee);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [W-1:0] b, input logic stop_v);
    sb_byte.push_back(int'(b));
    sb_err.push_back(stop_v ? 0 : 1);
    frames_ok++;
    rxd = 1'b0;
    idle(BITCLK);
    for (int i = 0; i < W; i++) begin
      rxd = b[i];
      idle(BITCLK);
    end
    rxd = stop_v;
    idle(BITCLK);
    rxd = 1'b1;
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int cap_before;
    idle(6);
    // R9 reset state
    chk(data_valid_o == 0 && frame_err_o == 0 && cap_valid_o == 0 && data_o == 0 && cap_bit_o == 0,
        "R9 reset outputs", int'({data_o, data_valid_o, frame_err_o, cap_valid_o, cap_bit_o}), 0);
    rst_ni = 1'b1;
    idle(200);
    // R3 R5 distinct patterns
    send_frame(8'h55, 1'b1);
    idle(137);
    send_frame(8'h00, 1'b1);
    idle(90);
    // R10 back to back
    send_frame(8'hFF, 1'b1);
    send_frame(8'hA3, 1'b1);
    idle(300);
    // R4 false start glitch
    cap_before = cap_cnt;
    rxd = 1'b0; idle(15); rxd = 1'b1;
    idle(300);
    chk(cap_cnt == cap_before, "R4 no capture on false start", cap_cnt, cap_before);
    chk(sb_byte.size() == 0, "R4 no byte on false start", sb_byte.size(), 0);
    // R7 framing error then clean frame
    send_frame(8'h3C, 1'b0);
    idle(200);
    send_frame(8'h81, 1'b1);
    idle(400);
    chk(sb_byte.size() == 0, "R3 all frames received", sb_byte.size(), 0);
    chk(cap_cnt == frames_ok * FRAME_SMP, "R8 capture count", cap_cnt, frames_ok * FRAME_SMP);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule